// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block is a bus master that answers a level-sensitive interrupt request. When the request is high and interrupts are enabled, it runs two interrupt acknowledge bus cycles on a 32-bit address and byte-enable bus. Each cycle behaves like a read. It has an address-strobe state (T1) and then a wait state (T2), and the wait state repeats until the active-low ready input is sampled low at a rising clock edge.

The two cycles are told apart by address bit 2. The first cycle addresses byte 4 and the second addresses byte 0. A fixed run of idle bus states separates them, and the bus stays locked for the whole sequence. The interrupt vector is the low data byte, taken when ready ends the second cycle. It is then presented for one clock together with a valid pulse. Higher data bits and the early next-address input have no effect.

Top module: `intack_seq`

## Requirements
- R1: A sequence starts only when `irq` and `int_en` are both high at a rising edge in the idle state. The first T1 state follows on the next cycle. With `int_en` low, the bus stays idle: `ads_n`, `lock_n`, `be_n` and the bus-definition outputs are all high.
- R2: The first acknowledge cycle drives byte address 4. `addr` (bits 31:2) equals 1 and `be_n` equals 4'b1110.
- R3: The second acknowledge cycle drives byte address 0. `addr` equals 0 and `be_n` equals 4'b1110.
- R4: Each cycle is T1 for exactly one clock and then T2. T2 repeats until `rdy_n` is sampled low at a rising edge. A low `rdy_n` during T1 or an idle state is ignored.
- R5: Exactly `IDLE_GAP` (default 4) idle bus states lie between the edge that ends the first cycle and the T1 of the second cycle. During them `ads_n` is high and `be_n` equals 4'b1111.
- R6: `mio_n`, `dc_n` and `wr_n` are all low in every T1 and T2 state of both cycles, and high otherwise.
- R7: `ads_n` is low in each T1 state only.
- R8: `lock_n` is low from the first T1 through the last T2, including the idle gap, and high once the sequence ends.
- R9: At the edge where `rdy_n` ends the second cycle, `data_in[7:0]` is captured. On the next cycle `vec_valid` is high for exactly one clock with `vector` equal to that byte. `data_in[31:8]` has no effect on it.
- R10: `next_addr_n` has no effect on any output.
- R11: A request is not accepted in the cycle where `vec_valid` is high. If `irq` stays high, the next T1 comes two cycles after the `vec_valid` cycle.
- R12: While `rst_n` is low, the block returns to idle: all active-low outputs are high, `vec_valid` is low and `addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level interrupt request |
| int_en | input | 1 | Interrupt enable flag |
| rdy_n | input | 1 | Active-low bus ready |
| next_addr_n | input | 1 | Active-low early next-address request (ignored) |
| data_in | input | DATA_W | Bus read data |
| addr | output | ADDR_W-2 | Address lines 31 down to 2 |
| be_n | output | 4 | Active-low byte enables |
| mio_n | output | 1 | Memory/IO bus-definition line |
| dc_n | output | 1 | Data/control bus-definition line |
| wr_n | output | 1 | Write/read bus-definition line |
| lock_n | output | 1 | Active-low bus lock |
| ads_n | output | 1 | Active-low address strobe |
| vec_valid | output | 1 | One-clock vector valid pulse |
| vector | output | VEC_W | Captured interrupt vector |

## Verification
Some properties are checked on every cycle:
- A strobe lasts one clock and always carries the acknowledge byte-enable pattern and bus type.
- The lock is never released while a strobe is active.
- The valid pulse is single and carries the byte that was on the bus at the previous edge.
- A lock starts only after an enabled request.

Other properties only the bench scenarios can show. These are the exact length of the idle gap, the cycle counts under varied wait states, the order of the byte 4 and byte 0 addresses, and the refusal of a held request in the valid cycle. The bench also shows that ready, next-address and upper data bits outside their windows change nothing.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int IDLE_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              int_en,
  input  logic              rdy_n,
  input  logic              next_addr_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-3:0] addr,
  output logic [3:0]        be_n,
  output logic              mio_n,
  output logic              dc_n,
  output logic              wr_n,
  output logic              lock_n,
  output logic              ads_n,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vector
);

  localparam int GW = (IDLE_GAP > 1) ? $clog2(IDLE_GAP) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(IDLE_GAP - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_A_T1, S_A_T2, S_GAP, S_B_T1, S_B_T2, S_DONE
  } state_t;

  state_t          st, st_nx;
  logic [GW-1:0]   gap_cnt;
  logic [VEC_W-1:0] vec_q;

  wire unused_in = &{1'b0, next_addr_n, data_in[DATA_W-1:VEC_W]};

  wire in_cyc = (st == S_A_T1) || (st == S_A_T2) || (st == S_B_T1) || (st == S_B_T2);
  wire in_seq = in_cyc || (st == S_GAP);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (irq && int_en) st_nx = S_A_T1;
      S_A_T1: st_nx = S_A_T2;
      S_A_T2: if (!rdy_n) st_nx = S_GAP;
      S_GAP:  if (gap_cnt == GAP_LAST) st_nx = S_B_T1;
      S_B_T1: st_nx = S_B_T2;
      S_B_T2: if (!rdy_n) st_nx = S_DONE;
      S_DONE: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gap_cnt <= '0;
      vec_q   <= '0;
    end else begin
      st <= st_nx;
      if (st == S_GAP) gap_cnt <= gap_cnt + 1'b1;
      else             gap_cnt <= '0;
      if (st == S_B_T2 && !rdy_n) vec_q <= data_in[VEC_W-1:0];
    end
  end

  assign addr      = (st == S_A_T1 || st == S_A_T2) ? (ADDR_W-2)'(1) : '0;
  assign be_n      = in_cyc ? 4'b1110 : 4'b1111;
  assign mio_n     = !in_cyc;
  assign dc_n      = !in_cyc;
  assign wr_n      = !in_cyc;
  assign ads_n     = !(st == S_A_T1 || st == S_B_T1);
  assign lock_n    = !in_seq;
  assign vec_valid = (st == S_DONE);
  assign vector    = vec_q;

endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              int_en,
  input logic [DATA_W-1:0] data_in,
  input logic [ADDR_W-3:0] addr,
  input logic [3:0]        be_n,
  input logic              mio_n,
  input logic              dc_n,
  input logic              wr_n,
  input logic              lock_n,
  input logic              ads_n,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vector
);
  AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) !ads_n |=> ads_n); // R7
  AST_STROBE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) !ads_n |-> (be_n == 4'b1110 && !mio_n && !dc_n && !wr_n)); // R6
  AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) !ads_n |-> !lock_n); // R8
  AST_STROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !ads_n |-> (addr <= (ADDR_W-2)'(1))); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |=> !vec_valid); // R9
  AST_VALID_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(vec_valid) |-> vector == $past(data_in[VEC_W-1:0])); // R9
  AST_VALID_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |-> (lock_n && ads_n)); // R11
  AST_LOCK_START: assert property (@(posedge clk) disable iff (!rst_n) $fell(lock_n) |-> $past(irq && int_en)); // R1
endmodule

bind intack_seq intack_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .int_en(int_en), .data_in(data_in),
  .addr(addr), .be_n(be_n), .mio_n(mio_n), .dc_n(dc_n), .wr_n(wr_n),
  .lock_n(lock_n), .ads_n(ads_n), .vec_valid(vec_valid), .vector(vector)
);

// File: tb/tb_intack_seq.sv
`timescale 1ns/1ps
module tb_intack_seq;
  localparam int GAP = 4;

  logic clk = 0, rst_n = 0, irq = 0, int_en = 0, rdy_n = 1, next_addr_n = 1;
  logic [31:0] data_in = '0;
  logic [29:0] addr;
  logic [3:0]  be_n;
  logic mio_n, dc_n, wr_n, lock_n, ads_n, vec_valid;
  logic [7:0]  vector;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  intack_seq #(.IDLE_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .int_en(int_en), .rdy_n(rdy_n),
    .next_addr_n(next_addr_n), .data_in(data_in), .addr(addr), .be_n(be_n),
    .mio_n(mio_n), .dc_n(dc_n), .wr_n(wr_n), .lock_n(lock_n), .ads_n(ads_n),
    .vec_valid(vec_valid), .vector(vector)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // packs: {ads_n, lock_n, be_n, mio_n, dc_n, wr_n, vec_valid}
  function automatic logic [9:0] pk();
    return {ads_n, lock_n, be_n, mio_n, dc_n, wr_n, vec_valid};
  endfunction

  task automatic idle_chk(input string req);
    chk(pk() == 10'b11_1111_111_0 && addr == 0, req, {22'd0, pk()}, {22'd0, 10'b1111111110});
  endtask

  task automatic run_seq(input int w1, input int w2, input logic [7:0] vec, input logic [23:0] junk);
    @(negedge clk); irq = 1; int_en = 1; next_addr_n = 0;
    @(negedge clk); irq = 0;
    // R2 R7 R6 first T1
    chk(pk() == 10'b0_0_1110_000_0 && addr == 30'd1, "R2", {addr[21:0], pk()}, {22'd1, 10'b0011100000});
    rdy_n = (w1 == 0) ? 1'b0 : 1'b1;
    for (int k = 0; k <= w1; k++) begin
      @(negedge clk);
      chk(pk() == 10'b1_0_1110_000_0 && addr == 30'd1, "R4", {addr[21:0], pk()}, {22'd1, 10'b1011100000});
      rdy_n = (k == w1) ? 1'b0 : 1'b1;
      next_addr_n = k[0];
    end
    for (int g = 0; g < GAP; g++) begin
      @(negedge clk);
      rdy_n = 0;
      chk(pk() == 10'b1_0_1111_111_0 && addr == 0, "R5", {addr[21:0], pk()}, {22'd0, 10'b1011111110});
    end
    @(negedge clk);
    chk(pk() == 10'b0_0_1110_000_0 && addr == 0, "R3", {addr[21:0], pk()}, {22'd0, 10'b0011100000});
    rdy_n = (w2 == 0) ? 1'b0 : 1'b1;
    for (int k = 0; k <= w2; k++) begin
      @(negedge clk);
      chk(pk() == 10'b1_0_1110_000_0 && addr == 0, "R4", {addr[21:0], pk()}, {22'd0, 10'b1011100000});
      rdy_n = (k == w2) ? 1'b0 : 1'b1;
      data_in = (k == w2) ? {junk, vec} : {~junk, ~vec};
    end
    @(negedge clk);
    rdy_n = 1; next_addr_n = 1; data_in = 32'hFFFF_FFFF;
    chk(vec_valid && vector == vec && lock_n && ads_n, "R9", {23'd0, vec_valid, vector}, {23'd1, 1'b1, vec});
    @(negedge clk);
    idle_chk("R8");
  endtask

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    idle_chk("R12");
    rst_n = 1;
    // R1: disabled request ignored, also ready and next-address (R10)
    irq = 1; int_en = 0; rdy_n = 0; next_addr_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      idle_chk("R1");
      chk(!vec_valid, "R10", {31'd0, vec_valid}, 32'd0);
    end
    irq = 0; rdy_n = 1; next_addr_n = 1;
    // wait-state sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        run_seq(a, b, 8'(a * 4 + b + 200), 24'hA5C3_00 ^ 24'(a * 16 + b));
    // vector sweep
    for (int v = 0; v < 256; v++)
      run_seq(v % 3, (v / 3) % 4, 8'(v), 24'(v * 4099));
    // R11: held request not accepted in valid cycle
    @(negedge clk); irq = 1; int_en = 1; rdy_n = 0;
    @(negedge clk);
    chk(!ads_n && addr == 30'd1, "R11", {31'd0, ads_n}, 32'd0);
    for (int n = 0; n < 1 + 1 + GAP + 1 + 1; n++) @(negedge clk);
    chk(vec_valid, "R11", {31'd0, vec_valid}, 32'd1);
    @(negedge clk);
    chk(ads_n && lock_n, "R11", {30'd0, ads_n, lock_n}, 32'd3);
    @(negedge clk);
    chk(!ads_n && addr == 30'd1, "R11", {31'd0, ads_n}, 32'd0);
    irq = 0;
    // R12: reset mid-sequence
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    idle_chk("R12");
    rst_n = 1; rdy_n = 1;
    @(negedge clk);
    idle_chk("R12");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule